// File: doc/BRIEF.md
# Per-User Bad-Pulse Watchdog

This block protects a pulsed beam line by tracking the health of each timing user on its own. Every user has a counter. The counter starts at an operator-set ceiling. It drops by one on each bad-pulse verdict for that user and climbs by one on each good verdict. When a bad verdict drives it to zero, the user trips. The trip stays latched until an operator resets that one user.

A beam permit exists only inside a window of fixed length. The window opens when a new machine cycle is announced. It opens only if that cycle's user has a non-zero, untripped counter and the supervising software has sent a keep-alive since the previous accepted cycle start. The permit is driven on two identical lines so that a downstream interlock can take both. Classifying pulses and the configuration path are done elsewhere. The block receives ready-made verdicts and a ceiling value.

Top module: `pulse_watchdog`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `permit_a`, `permit_b` and `tripped` are all zero. Reset loads every user counter with `max_count`, so an untouched user trips on exactly its `max_count`-th bad verdict.
- R2: A bad verdict (`verdict_kind` = 2) lowers the addressed user's counter by one. The verdict that brings the counter to zero sets that user's bit in `tripped` in the following cycle. No other user's bit changes.
- R3: A good verdict (`verdict_kind` = 1) raises the addressed user's counter by one. The counter never rises above `max_count`; extra good verdicts at the ceiling are lost.
- R4: An empty verdict (`verdict_kind` = 0, and the unused code 3) leaves the counter unchanged.
- R5: A tripped user stays tripped whatever verdicts arrive. Only a reset of that user clears the bit.
- R6: A user reset (`user_reset` with `user_reset_id`) clears that user's trip bit and reloads its counter with `max_count`. It has no effect on any other user.
- R7: If a user reset and a verdict address the same user in the same cycle, the reset wins and the verdict is discarded.
- R8: An accepted cycle start that qualifies raises the permit in the next cycle. The permit then stays high for exactly `WIN_CYCLES` cycles.
- R9: A window opens only if `keepalive` was seen after the previous accepted cycle start. Each accepted start consumes the record. A keep-alive in the same cycle as an accepted start counts for the next cycle. After reset no keep-alive is recorded.
- R10: A `cycle_start` that arrives while a window is open is ignored entirely. It neither lengthens the window nor consumes the keep-alive record.
- R11: `permit_a` and `permit_b` are always equal. Both are low outside a window.
- R12: No window opens for a cycle whose user is tripped or has a zero counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| max_count | input | CNT_W | Operator ceiling loaded into counters |
| cycle_start | input | 1 | One-cycle strobe announcing a new machine cycle |
| cycle_user | input | UID_W | User of the announced cycle |
| keepalive | input | 1 | Software alive strobe |
| verdict_valid | input | 1 | Verdict strobe |
| verdict_user | input | UID_W | User the verdict belongs to |
| verdict_kind | input | 2 | 0 empty, 1 good, 2 bad, 3 treated as empty |
| user_reset | input | 1 | Operator reset strobe for one user |
| user_reset_id | input | UID_W | User to reset |
| permit_a | output | 1 | Beam permit, line A |
| permit_b | output | 1 | Beam permit, line B (same value as A) |
| tripped | output | N_USERS | Latched trip flag per user |

## Verification
The two functions that can meet in one cycle are an operator reset and a bad verdict aimed at the same user. The bench provokes this on a user that is already tripped, with both strobes driven in the same cycle. It judges the result twice. First, the trip bit must be clear in the next cycle. Second, exactly `max_count` further bad verdicts must be needed to trip the user again. If the verdict had won, the counter would sit one lower and the user would trip one verdict early. A second overlap, a cycle start during an open window, is judged by the window's closing cycle.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        VK_EMPTY = 2'd0,
        VK_GOOD  = 2'd1,
        VK_BAD   = 2'd2,
        VK_SPARE = 2'd3
    } verdict_e;

    localparam int PERMIT_LANES = 2;

    function automatic logic moves_up(verdict_e k);
        return k == VK_GOOD;
    endfunction

    function automatic logic moves_down(verdict_e k);
        return k == VK_BAD;
    endfunction

endpackage

// File: rtl/pw_keepalive.sv
module pw_keepalive (
    input  logic clk,
    input  logic rst,
    input  logic keepalive,
    input  logic start_taken,
    output logic ka_ok
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else if (start_taken) begin
            seen_q <= keepalive;
        end else if (keepalive) begin
            seen_q <= 1'b1;
        end
    end

    assign ka_ok = seen_q;
endmodule

// File: rtl/pw_window.sv
module pw_window
    import pw_pkg::*;
#(
    parameter int WIN_CYCLES = 100000,
    localparam int TW = $clog2(WIN_CYCLES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_req,
    output logic                    busy,
    output logic [PERMIT_LANES-1:0] lanes
);
    logic          open_q, open_d;
    logic [TW-1:0] rem_q, rem_d;
    logic          start_ok;

    assign start_ok = start_req & ~open_q;

    always_comb begin
        open_d = open_q;
        rem_d  = rem_q;
        if (start_ok) begin
            open_d = 1'b1;
            rem_d  = TW'(WIN_CYCLES - 1);
        end else if (open_q) begin
            if (rem_q == '0) begin
                open_d = 1'b0;
            end else begin
                rem_d = rem_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            rem_q  <= '0;
        end else begin
            open_q <= open_d;
            rem_q  <= rem_d;
        end
    end

    for (genvar l = 0; l < PERMIT_LANES; l++) begin : g_lane
        logic lane_q;
        always_ff @(posedge clk) begin
            if (rst) lane_q <= 1'b0;
            else     lane_q <= open_d;
        end
        assign lanes[l] = lane_q;
    end

    assign busy = open_q;
endmodule

// File: rtl/pw_user_bank.sv
module pw_user_bank
    import pw_pkg::*;
#(
    parameter int N_USERS = 16,
    parameter int CNT_W   = 8,
    localparam int UID_W  = (N_USERS > 1) ? $clog2(N_USERS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   max_count,
    input  logic               vd_valid,
    input  logic [UID_W-1:0]   vd_user,
    input  verdict_e           vd_kind,
    input  logic               ur_valid,
    input  logic [UID_W-1:0]   ur_user,
    output logic [N_USERS-1:0] nonzero,
    output logic [N_USERS-1:0] tripped
);
    for (genvar u = 0; u < N_USERS; u++) begin : g_user
        logic [CNT_W-1:0] cnt_q, cnt_d;
        logic             trip_q;
        logic             hit_vd, hit_ur;

        assign hit_vd = vd_valid && (vd_user == UID_W'(u));
        assign hit_ur = ur_valid && (ur_user == UID_W'(u));

        always_comb begin
            cnt_d = cnt_q;
            if (moves_up(vd_kind)) begin
                if (cnt_q < max_count) cnt_d = cnt_q + 1'b1;
            end else if (moves_down(vd_kind)) begin
                if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q  <= max_count;
                trip_q <= 1'b0;
            end else if (hit_ur) begin
                cnt_q  <= max_count;
                trip_q <= 1'b0;
            end else if (hit_vd && !trip_q) begin
                cnt_q <= cnt_d;
                if (moves_down(vd_kind) && cnt_d == '0) trip_q <= 1'b1;
            end
        end

        assign nonzero[u] = (cnt_q != '0);
        assign tripped[u] = trip_q;
    end
endmodule

// File: rtl/pulse_watchdog.sv
module pulse_watchdog
    import pw_pkg::*;
#(
    parameter int N_USERS    = 16,
    parameter int CNT_W      = 8,
    parameter int WIN_CYCLES = 100000,
    localparam int UID_W     = (N_USERS > 1) ? $clog2(N_USERS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   max_count,
    input  logic               cycle_start,
    input  logic [UID_W-1:0]   cycle_user,
    input  logic               keepalive,
    input  logic               verdict_valid,
    input  logic [UID_W-1:0]   verdict_user,
    input  logic [1:0]         verdict_kind,
    input  logic               user_reset,
    input  logic [UID_W-1:0]   user_reset_id,
    output logic               permit_a,
    output logic               permit_b,
    output logic [N_USERS-1:0] tripped
);
    logic [N_USERS-1:0]      nonzero;
    logic [N_USERS-1:0]      trip_vec;
    logic                    busy;
    logic                    ka_ok;
    logic                    start_taken;
    logic                    start_req;
    logic [PERMIT_LANES-1:0] lanes;

    assign start_taken = cycle_start & ~busy;
    assign start_req   = cycle_start & ka_ok & nonzero[cycle_user] & ~trip_vec[cycle_user];

    pw_user_bank #(
        .N_USERS (N_USERS),
        .CNT_W   (CNT_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .max_count (max_count),
        .vd_valid  (verdict_valid),
        .vd_user   (verdict_user),
        .vd_kind   (verdict_e'(verdict_kind)),
        .ur_valid  (user_reset),
        .ur_user   (user_reset_id),
        .nonzero   (nonzero),
        .tripped   (trip_vec)
    );

    pw_keepalive u_ka (
        .clk         (clk),
        .rst         (rst),
        .keepalive   (keepalive),
        .start_taken (start_taken),
        .ka_ok       (ka_ok)
    );

    pw_window #(
        .WIN_CYCLES (WIN_CYCLES)
    ) u_win (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .busy      (busy),
        .lanes     (lanes)
    );

    assign permit_a = lanes[0];
    assign permit_b = lanes[1];
    assign tripped  = trip_vec;
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
    parameter int N_USERS    = 16,
    parameter int WIN_CYCLES = 100000,
    localparam int UID_W     = (N_USERS > 1) ? $clog2(N_USERS) : 1,
    localparam int TW        = $clog2(WIN_CYCLES + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               cycle_start,
    input logic [UID_W-1:0]   cycle_user,
    input logic               keepalive,
    input logic               user_reset,
    input logic [UID_W-1:0]   user_reset_id,
    input logic               permit_a,
    input logic               permit_b,
    input logic [N_USERS-1:0] tripped
);
    logic [TW-1:0]      run_len;
    logic               ka_ref;
    logic [N_USERS-1:0] rmask;

    always_ff @(posedge clk) begin
        if (rst)           run_len <= '0;
        else if (permit_a) run_len <= run_len + 1'b1;
        else               run_len <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst)                           ka_ref <= 1'b0;
        else if (cycle_start && !permit_a) ka_ref <= keepalive;
        else if (keepalive)                ka_ref <= 1'b1;
    end

    always_comb begin
        rmask = '0;
        if (user_reset) rmask[user_reset_id] = 1'b1;
    end

    assert_lanes_equal_R11: assert property (@(posedge clk) disable iff (rst)
        permit_a == permit_b);

    assert_window_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        permit_a |-> (run_len < TW'(WIN_CYCLES)));

    assert_window_length_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(permit_a) |-> (run_len == TW'(WIN_CYCLES)));

    assert_opens_on_start_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(permit_a) |-> $past(cycle_start));

    assert_needs_keepalive_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(permit_a) |-> $past(ka_ref));

    assert_no_window_tripped_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(permit_a) |-> !$past(tripped[cycle_user]));

    assert_trip_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (|(tripped & ~rmask)) |=> (((($past(tripped) & ~$past(rmask))) & ~tripped) == '0));

    assert_reset_clears_R6: assert property (@(posedge clk) disable iff (rst)
        user_reset |=> !tripped[$past(user_reset_id)]);
endmodule

bind pulse_watchdog pw_checker #(
    .N_USERS    (N_USERS),
    .WIN_CYCLES (WIN_CYCLES)
) u_pw_checker (
    .clk           (clk),
    .rst           (rst),
    .cycle_start   (cycle_start),
    .cycle_user    (cycle_user),
    .keepalive     (keepalive),
    .user_reset    (user_reset),
    .user_reset_id (user_reset_id),
    .permit_a      (permit_a),
    .permit_b      (permit_b),
    .tripped       (tripped)
);

// File: tb/pulse_watchdog_bench.sv
`timescale 1ns/1ps
module pulse_watchdog_bench;
    localparam int NU  = 16;
    localparam int CW  = 4;
    localparam int WIN = 12;
    localparam logic [1:0] K_EMPTY = 2'd0;
    localparam logic [1:0] K_GOOD  = 2'd1;
    localparam logic [1:0] K_BAD   = 2'd2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] max_count = 4'd3;
    logic          cycle_start = 1'b0;
    logic [3:0]    cycle_user = '0;
    logic          keepalive = 1'b0;
    logic          verdict_valid = 1'b0;
    logic [3:0]    verdict_user = '0;
    logic [1:0]    verdict_kind = '0;
    logic          user_reset = 1'b0;
    logic [3:0]    user_reset_id = '0;
    logic          permit_a, permit_b;
    logic [NU-1:0] tripped;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        int          at;
        int          what;
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_watchdog #(
        .N_USERS(NU), .CNT_W(CW), .WIN_CYCLES(WIN)
    ) u_pulse_watchdog (
        .clk(clk), .rst(rst), .max_count(max_count),
        .cycle_start(cycle_start), .cycle_user(cycle_user),
        .keepalive(keepalive), .verdict_valid(verdict_valid),
        .verdict_user(verdict_user), .verdict_kind(verdict_kind),
        .user_reset(user_reset), .user_reset_id(user_reset_id),
        .permit_a(permit_a), .permit_b(permit_b), .tripped(tripped)
    );

    // monitor: pop every expectation due in this cycle and compare
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at == cyc) begin
                checks++;
                if (sbq[i].what == 0) begin
                    if (permit_a !== sbq[i].val[0] || permit_b !== sbq[i].val[0]) begin
                        failures++;
                        $display("FAIL %s cyc=%0d permit a/b actual=%b%b expected=%b%b",
                                 sbq[i].tag, cyc, permit_a, permit_b, sbq[i].val[0], sbq[i].val[0]);
                    end
                end else begin
                    if (tripped !== sbq[i].val) begin
                        failures++;
                        $display("FAIL %s cyc=%0d tripped actual=%h expected=%h",
                                 sbq[i].tag, cyc, tripped, sbq[i].val);
                    end
                end
                sbq.delete(i);
            end
        end
    end

    task automatic push(int d, int what, logic [15:0] v, string tag);
        exp_t e;
        e.at = cyc + d; e.what = what; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic verdict(int u, logic [1:0] k, logic [15:0] exp_trip, string tag);
        verdict_valid = 1'b1; verdict_user = 4'(u); verdict_kind = k;
        push(1, 1, exp_trip, tag);
        @(negedge clk);
        verdict_valid = 1'b0;
    endtask

    task automatic ureset(int u, logic [15:0] exp_trip, string tag);
        user_reset = 1'b1; user_reset_id = 4'(u);
        push(1, 1, exp_trip, tag);
        @(negedge clk);
        user_reset = 1'b0;
    endtask

    task automatic collide(int u, logic [15:0] exp_trip, string tag);
        user_reset = 1'b1; user_reset_id = 4'(u);
        verdict_valid = 1'b1; verdict_user = 4'(u); verdict_kind = K_BAD;
        push(1, 1, exp_trip, tag);
        @(negedge clk);
        user_reset = 1'b0; verdict_valid = 1'b0;
    endtask

    task automatic ka();
        keepalive = 1'b1;
        @(negedge clk);
        keepalive = 1'b0;
    endtask

    task automatic start(int u, bit opens, string tag);
        cycle_start = 1'b1; cycle_user = 4'(u);
        if (opens) begin
            for (int k = 1; k <= WIN; k++) push(k, 0, 16'h1, tag);
            push(WIN + 1, 0, 16'h0, tag);
        end else begin
            push(1, 0, 16'h0, tag);
            push(2, 0, 16'h0, tag);
        end
        @(negedge clk);
        cycle_start = 1'b0;
    endtask

    task automatic raw_start(int u);
        cycle_start = 1'b1; cycle_user = 4'(u);
        @(negedge clk);
        cycle_start = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        push(1, 0, 16'h0, "R1 reset permit");
        push(1, 1, 16'h0, "R1 reset trips");
        rst = 1'b0;
        idle(2);

        // R9: no keep-alive recorded after reset
        start(0, 0, "R9 no keepalive");
        idle(2);

        // R8 window length; R10 start inside window is ignored
        ka();
        start(0, 1, "R8 R10 window");
        idle(2);
        ka();
        raw_start(0);
        idle(WIN + 2);
        // R10: ignored start did not consume the keep-alive record
        start(0, 1, "R10 record kept");
        idle(WIN + 2);
        // R9: record consumed by the previous accepted start
        start(0, 0, "R9 consumed");
        idle(2);

        // R2: three bad verdicts trip user 1
        verdict(1, K_BAD, 16'h0000, "R2");
        verdict(1, K_BAD, 16'h0000, "R2");
        verdict(1, K_BAD, 16'h0002, "R2 trip");

        // R12: tripped user gets no window
        ka();
        start(1, 0, "R12 tripped");

        // R5: good verdicts do not clear the trip
        verdict(1, K_GOOD, 16'h0002, "R5");
        verdict(1, K_GOOD, 16'h0002, "R5");

        // R4: empty verdicts leave the counter
        verdict(2, K_BAD,   16'h0002, "R4");
        verdict(2, K_EMPTY, 16'h0002, "R4");
        verdict(2, K_EMPTY, 16'h0002, "R4");
        verdict(2, 2'd3,    16'h0002, "R4");
        verdict(2, K_BAD,   16'h0002, "R4");
        verdict(2, K_BAD,   16'h0006, "R4 trip");

        // R3: good verdicts saturate at max
        verdict(3, K_BAD,  16'h0006, "R3");
        verdict(3, K_GOOD, 16'h0006, "R3");
        verdict(3, K_GOOD, 16'h0006, "R3");
        verdict(3, K_GOOD, 16'h0006, "R3");
        verdict(3, K_BAD,  16'h0006, "R3");
        verdict(3, K_BAD,  16'h0006, "R3");
        verdict(3, K_BAD,  16'h000E, "R3 trip");

        // R6: per-user reset reloads max, others kept
        ureset(2, 16'h000A, "R6 clear");
        verdict(2, K_BAD, 16'h000A, "R6");
        verdict(2, K_BAD, 16'h000A, "R6");
        verdict(2, K_BAD, 16'h000E, "R6 reload");
        ureset(2, 16'h000A, "R6 clear again");

        // R7: reset and bad verdict on the same user together
        collide(1, 16'h0008, "R7 reset wins");
        verdict(1, K_BAD, 16'h0008, "R7");
        verdict(1, K_BAD, 16'h0008, "R7");
        verdict(1, K_BAD, 16'h000A, "R7 full reload");

        // R12 positive: after reset the user gets a window again
        ureset(1, 16'h0008, "R6");
        ka();
        start(1, 1, "R12 R11 reopened");
        idle(WIN + 2);

        // R1: untouched user 5 holds max from reset
        verdict(5, K_BAD, 16'h0008, "R1");
        verdict(5, K_BAD, 16'h0008, "R1");
        verdict(5, K_BAD, 16'h0028, "R1 max at reset");

        idle(3);
        if (sbq.size() != 0) begin
            failures += sbq.size();
            $display("FAIL scoreboard left %0d unchecked items, expected 0", sbq.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule